// File: doc/BRIEF.md
# Protected Byte Memory Programming Controller

This block keeps a byte-wide memory of 256 locations in registers, together with 32 one-way lock bits. Lock bit n belongs to byte n, for n from 0 to 31. A command front end passes in single requests. An update request asks to give one byte a new value. A lock request asks to freeze one of the 32 lowest bytes. The controller turns each accepted request into timed phases, modelled on floating-gate programming. An erase phase sets the byte to all ones. A write phase can only clear bits. The length of each phase is a parameter counted in clock cycles.

Programming stays disabled after power-up until the front end signals, with a pulse on `readSeen`, that a read command or an answer-to-reset has taken place. While it is disabled, every request completes as a no-op. The controller skips work it does not need: an update that leaves the byte unchanged runs no phase, and an update that only clears bits runs no erase phase. A separate abort input stops the sequence in progress. It never leaves a byte holding a value partway between its old and new contents.

Top module: `prot_mem_ctrl`

## Requirements
- R1: After `rstN` is low, `busy` and `done` are 0, every byte reads 0xFF and every lock read byte is 0xFF.
- R2: `rdData` shows byte `rdAddr` in the same cycle. Bit i of `lockRdByte` is the lock bit of address 8*`lockRdIdx`+i, and 1 means unlocked.
- R3: An update whose data equals the stored byte runs no phase. `busy` is high for exactly 1 cycle and the byte is unchanged.
- R4: An update whose data has no 1 bit where the stored byte has a 0 runs only a write phase. `busy` lasts 1+WRITE_CYCLES cycles and the byte then equals the data.
- R5: Any other allowed update runs an erase phase of ERASE_CYCLES cycles and then a write phase. The byte reads 0xFF during the write phase, and `busy` lasts 1+ERASE_CYCLES+WRITE_CYCLES cycles.
- R6: An update to an address below 32 whose lock bit is 0 leaves the byte unchanged, with `busy` high for 1 cycle.
- R7: A lock request clears the lock bit of its address after one write phase (`busy` lasts 1+WRITE_CYCLES) only if the address is below 32, the bit is still 1 and the data equals the stored byte. Any other lock request is a 1-cycle no-op. A cleared lock bit never returns to 1.
- R8: Until `readSeen` has been high at a clock edge after reset, every request is a 1-cycle no-op that changes nothing.
- R9: A request is taken only when `busy` is 0. Requests made while busy are dropped. `done` pulses for one cycle, in the first cycle after a sequence in which `busy` is 0.
- R10: `abortIn` high at an edge makes `busy` 0 with no `done` pulse. The target byte keeps its value from before the phase, or 0xFF if the erase phase has already finished. While idle, `abortIn` blocks a request made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low power-up reset |
| abortIn | input | 1 | Abort the sequence in progress |
| readSeen | input | 1 | Pulse: a read or answer-to-reset occurred, enabling programming |
| reqValid | input | 1 | Request present |
| reqLock | input | 1 | 1 = lock request, 0 = update request |
| reqAddr | input | 8 | Target byte address |
| reqData | input | 8 | New byte value, or the comparison value for a lock request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rdAddr | input | 8 | Data read address |
| rdData | output | 8 | Byte at `rdAddr` |
| lockRdIdx | input | 2 | Lock byte index |
| lockRdByte | output | 8 | Eight lock bits selected by `lockRdIdx` |

## Verification
The case that needs the most care is an abort and a phase commit arriving at the same clock edge. The bench holds `abortIn` high in the final cycle of an erase phase and expects the byte to keep its old value, with no `done`. It then holds `abortIn` high in the middle of a later write phase, after the erase has been committed, and expects 0xFF. A second collision is tested with a request and an abort raised together while the block is idle. In that case the bench expects `busy` to stay 0 and the byte to stay the same.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVAL  = 2'd1,
    ST_ERASE = 2'd2,
    ST_WRITE = 2'd3
  } pmcState_t;

  // control -> datapath
  typedef struct packed {
    logic capture;
    logic eraseStb;
    logic writeStb;
  } pmcStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic opValid;
    logic needErase;
    logic isLock;
  } pmcFlags_t;

endpackage

// File: rtl/pmc_ctrl.sv
`timescale 1ns/1ps
module pmc_ctrl
  import pmc_pkg::*;
#(
  parameter int ERASE_CYCLES = 8,
  parameter int WRITE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       abortIn,
  input  logic       readSeen,
  input  pmcFlags_t  flags,
  output pmcStrobe_t stb,
  output logic       busy,
  output logic       done,
  output logic       armed
);

  localparam int MAX_CYC = (ERASE_CYCLES > WRITE_CYCLES) ? ERASE_CYCLES : WRITE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);
  localparam logic [CNT_W-1:0] WRITE_LOAD = CNT_W'(WRITE_CYCLES - 1);

  pmcState_t        state, stateN;
  logic [CNT_W-1:0] cnt, cntN;
  logic             doneN;
  logic             phaseEnd;

  assign phaseEnd = (cnt == '0);

  always_comb begin
    stb          = '0;
    stb.capture  = (state == ST_IDLE) && reqValid && !abortIn;
    stb.eraseStb = (state == ST_ERASE) && phaseEnd && !abortIn;
    stb.writeStb = (state == ST_WRITE) && phaseEnd && !abortIn;
  end

  always_comb begin
    stateN = state;
    cntN   = cnt;
    doneN  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (stb.capture) stateN = ST_EVAL;
      end
      ST_EVAL: begin
        if (!armed || !flags.opValid) begin
          stateN = ST_IDLE;
          doneN  = 1'b1;
        end else if (flags.isLock || !flags.needErase) begin
          stateN = ST_WRITE;
          cntN   = WRITE_LOAD;
        end else begin
          stateN = ST_ERASE;
          cntN   = ERASE_LOAD;
        end
      end
      ST_ERASE: begin
        if (phaseEnd) begin
          stateN = ST_WRITE;
          cntN   = WRITE_LOAD;
        end else begin
          cntN = cnt - 1'b1;
        end
      end
      ST_WRITE: begin
        if (phaseEnd) begin
          stateN = ST_IDLE;
          doneN  = 1'b1;
        end else begin
          cntN = cnt - 1'b1;
        end
      end
      default: stateN = ST_IDLE;
    endcase
    if (abortIn) begin
      stateN = ST_IDLE;
      doneN  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      state <= stateN;
      cnt   <= cntN;
      done  <= doneN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         armed <= 1'b0;
    else if (readSeen) armed <= 1'b1;
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/pmc_datapath.sv
`timescale 1ns/1ps
module pmc_datapath
  import pmc_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int LOCK_COUNT = 32,
  localparam int LOCK_BYTES = LOCK_COUNT / DATA_W,
  localparam int LIDX_W     = (LOCK_BYTES > 1) ? $clog2(LOCK_BYTES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  pmcStrobe_t            stb,
  input  logic                  reqLock,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DATA_W-1:0]     reqData,
  input  logic [ADDR_W-1:0]     rdAddr,
  input  logic [LIDX_W-1:0]     lockRdIdx,
  output pmcFlags_t             flags,
  output logic [DATA_W-1:0]     rdData,
  output logic [DATA_W-1:0]     lockRdByte,
  output logic                  lockQ,
  output logic [ADDR_W-1:0]     addrQ,
  output logic [DATA_W-1:0]     dataQ,
  output logic [DATA_W-1:0]     curByte,
  output logic [LOCK_COUNT-1:0] lockBits
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int LB_W  = $clog2(LOCK_COUNT);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] lockBytes [LOCK_BYTES];
  logic [LB_W-1:0]   lockIdx;
  logic              inLockRange;
  logic              curLockBit;

  // captured request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ <= 1'b0;
      addrQ <= '0;
      dataQ <= '0;
    end else if (stb.capture) begin
      lockQ <= reqLock;
      addrQ <= reqAddr;
      dataQ <= reqData;
    end
  end

  assign curByte     = mem[addrQ];
  assign lockIdx     = addrQ[LB_W-1:0];
  assign inLockRange = ({1'b0, addrQ} < (ADDR_W+1)'(LOCK_COUNT));
  assign curLockBit  = lockBits[lockIdx];

  always_comb begin
    flags        = '0;
    flags.isLock = lockQ;
    if (lockQ) begin
      flags.opValid = inLockRange && curLockBit && (dataQ == curByte);
    end else begin
      flags.opValid   = !(inLockRange && !curLockBit) && (dataQ != curByte);
      flags.needErase = |(dataQ & ~curByte);
    end
  end

  // byte array
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (stb.eraseStb) begin
      mem[addrQ] <= '1;
    end else if (stb.writeStb && !lockQ) begin
      mem[addrQ] <= mem[addrQ] & dataQ;
    end
  end

  // one-way lock bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockBits <= '1;
    end else if (stb.writeStb && lockQ) begin
      lockBits[lockIdx] <= 1'b0;
    end
  end

  // read ports
  genvar g;
  generate
    for (g = 0; g < LOCK_BYTES; g++) begin : gLockByte
      assign lockBytes[g] = lockBits[g*DATA_W +: DATA_W];
    end
  endgenerate

  assign rdData     = mem[rdAddr];
  assign lockRdByte = lockBytes[lockRdIdx];

endmodule

// File: rtl/prot_mem_ctrl.sv
`timescale 1ns/1ps
module prot_mem_ctrl
  import pmc_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int LOCK_COUNT   = 32,
  parameter int ERASE_CYCLES = 8,
  parameter int WRITE_CYCLES = 8,
  localparam int LOCK_BYTES  = LOCK_COUNT / DATA_W,
  localparam int LIDX_W      = (LOCK_BYTES > 1) ? $clog2(LOCK_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              abortIn,
  input  logic              readSeen,
  input  logic              reqValid,
  input  logic              reqLock,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              busy,
  output logic              done,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [LIDX_W-1:0] lockRdIdx,
  output logic [DATA_W-1:0] lockRdByte
);

  pmcStrobe_t            stbW;
  pmcFlags_t             flagsW;
  logic                  armedW;
  logic                  lockQW;
  logic [ADDR_W-1:0]     addrQW;
  logic [DATA_W-1:0]     dataQW;
  logic [DATA_W-1:0]     curByteW;
  logic [LOCK_COUNT-1:0] lockBitsW;

  pmc_ctrl #(
    .ERASE_CYCLES(ERASE_CYCLES),
    .WRITE_CYCLES(WRITE_CYCLES)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .abortIn  (abortIn),
    .readSeen (readSeen),
    .flags    (flagsW),
    .stb      (stbW),
    .busy     (busy),
    .done     (done),
    .armed    (armedW)
  );

  pmc_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .LOCK_COUNT(LOCK_COUNT)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stbW),
    .reqLock   (reqLock),
    .reqAddr   (reqAddr),
    .reqData   (reqData),
    .rdAddr    (rdAddr),
    .lockRdIdx (lockRdIdx),
    .flags     (flagsW),
    .rdData    (rdData),
    .lockRdByte(lockRdByte),
    .lockQ     (lockQW),
    .addrQ     (addrQW),
    .dataQ     (dataQW),
    .curByte   (curByteW),
    .lockBits  (lockBitsW)
  );

endmodule

// File: rtl/pmc_checker.sv
`timescale 1ns/1ps
module pmc_checker
  import pmc_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int LOCK_COUNT = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  abortIn,
  input logic                  busy,
  input logic                  done,
  input logic                  armed,
  input pmcStrobe_t            stb,
  input logic                  lockQ,
  input logic [ADDR_W-1:0]     addrQ,
  input logic [DATA_W-1:0]     dataQ,
  input logic [DATA_W-1:0]     curByte,
  input logic [LOCK_COUNT-1:0] lockBits
);

  localparam int LB_W = $clog2(LOCK_COUNT);

  logic addrInLock;
  assign addrInLock = ({1'b0, addrQ} < (ADDR_W+1)'(LOCK_COUNT));

  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  assert_lock_one_way_R7: assert property (@(posedge clk) disable iff (!rstN)
    (lockBits & ~$past(lockBits)) == '0);

  assert_disarmed_no_commit_R8: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> !(stb.eraseStb || stb.writeStb));

  assert_abort_to_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    abortIn |=> (!busy && !done));

  assert_erase_all_ones_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.eraseStb |=> (curByte == '1));

  assert_locked_no_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.writeStb && !lockQ && addrInLock) |-> lockBits[addrQ[LB_W-1:0]]);

  assert_write_clears_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.writeStb && !lockQ) |=> (curByte == ($past(curByte) & $past(dataQ))));

  assert_equal_skips_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.eraseStb && !lockQ) |-> (curByte != dataQ));

endmodule

bind prot_mem_ctrl pmc_checker #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .LOCK_COUNT(LOCK_COUNT)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .abortIn (abortIn),
  .busy    (busy),
  .done    (done),
  .armed   (armedW),
  .stb     (stbW),
  .lockQ   (lockQW),
  .addrQ   (addrQW),
  .dataQ   (dataQW),
  .curByte (curByteW),
  .lockBits(lockBitsW)
);

// File: tb/prot_mem_ctrl_tb_top.sv
`timescale 1ns/1ps
module prot_mem_ctrl_tb_top;

  localparam int E = 5;
  localparam int W = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       abortIn = 1'b0;
  logic       readSeen = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqLock = 1'b0;
  logic [7:0] reqAddr = '0;
  logic [7:0] reqData = '0;
  logic       busy, done;
  logic [7:0] rdAddr = '0;
  logic [7:0] rdData;
  logic [1:0] lockRdIdx = '0;
  logic [7:0] lockRdByte;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  prot_mem_ctrl #(
    .ERASE_CYCLES(E),
    .WRITE_CYCLES(W)
  ) dut_i (
    .clk(clk), .rstN(rstN), .abortIn(abortIn), .readSeen(readSeen),
    .reqValid(reqValid), .reqLock(reqLock), .reqAddr(reqAddr), .reqData(reqData),
    .busy(busy), .done(done), .rdAddr(rdAddr), .rdData(rdData),
    .lockRdIdx(lockRdIdx), .lockRdByte(lockRdByte)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] mMem [256];
  bit         mLk [32];
  bit         mArmed, mDone, mLock;
  int         mPh, mCnt, mAddr, mData;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mMem[i]) mMem[i] = 8'hFF;
      foreach (mLk[i]) mLk[i] = 1'b1;
      mArmed = 0; mDone = 0; mPh = 0; mCnt = 0;
    end else begin
      bit nd;
      bit ok;
      bit armedOld;
      logic [7:0] cur;
      nd = 0;
      armedOld = mArmed;
      if (abortIn) mPh = 0;
      else begin
        case (mPh)
          0: if (reqValid) begin
               mLock = reqLock; mAddr = reqAddr; mData = reqData; mPh = 1;
             end
          1: begin
               cur = mMem[mAddr];
               if (mLock) begin
                 ok = armedOld && mAddr < 32 && mLk[mAddr % 32] && (mData == cur);
                 if (ok) begin mPh = 3; mCnt = W; end
                 else begin mPh = 0; nd = 1; end
               end else begin
                 ok = armedOld && !(mAddr < 32 && !mLk[mAddr % 32]) && (mData != cur);
                 if (!ok) begin mPh = 0; nd = 1; end
                 else if ((mData & ~cur & 8'hFF) != 0) begin mPh = 2; mCnt = E; end
                 else begin mPh = 3; mCnt = W; end
               end
             end
          2: begin
               mCnt--;
               if (mCnt == 0) begin mMem[mAddr] = 8'hFF; mPh = 3; mCnt = W; end
             end
          default: begin
               mCnt--;
               if (mCnt == 0) begin
                 if (mLock) mLk[mAddr % 32] = 1'b0;
                 else mMem[mAddr] = mMem[mAddr] & mData[7:0];
                 mPh = 0; nd = 1;
               end
             end
        endcase
      end
      mDone = nd;
      if (readSeen) mArmed = 1;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    #1;
    if (rstN) begin
      logic [7:0] lb;
      for (int i = 0; i < 8; i++) lb[i] = mLk[lockRdIdx*8 + i];
      check(busy == (mPh != 0), "R9 busy vs model", busy, mPh != 0);
      check(done == mDone, "R9 done vs model", done, mDone);
      check(rdData == mMem[rdAddr], "R2 rdData vs model", rdData, mMem[rdAddr]);
      check(lockRdByte == lb, "R2 lockRdByte vs model", lockRdByte, lb);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic doReq(input bit lk, input int a, input int d, output int len, output bit dn);
    @(negedge clk);
    reqValid = 1; reqLock = lk; reqAddr = 8'(a); reqData = 8'(d); rdAddr = 8'(a);
    @(negedge clk);
    reqValid = 0;
    len = 0;
    while (busy) begin
      len++;
      @(negedge clk);
    end
    #1 dn = done;
  endtask

  task automatic peek(input int a, output int v);
    rdAddr = 8'(a);
    #1 v = rdData;
  endtask

  task automatic peekLock(input int idx, output int v);
    lockRdIdx = 2'(idx);
    #1 v = lockRdByte;
  endtask

  initial begin
    int len, v;
    bit dn;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset state
    check(busy == 0, "R1 busy after reset", busy, 0);
    check(done == 0, "R1 done after reset", done, 0);
    peek(0, v);   check(v == 8'hFF, "R1 byte 0", v, 8'hFF);
    peek(200, v); check(v == 8'hFF, "R1 byte 200", v, 8'hFF);
    for (int k = 0; k < 4; k++) begin
      peekLock(k, v); check(v == 8'hFF, "R1 lock byte", v, 8'hFF);
    end

    // R8 disarmed
    doReq(0, 40, 8'h12, len, dn);
    check(len == 1, "R8 disarmed busy length", len, 1);
    check(dn == 1, "R9 done after no-op", dn, 1);
    peek(40, v); check(v == 8'hFF, "R8 disarmed byte unchanged", v, 8'hFF);

    @(negedge clk); readSeen = 1;
    @(negedge clk); readSeen = 0;

    // R4 write only
    doReq(0, 40, 8'h12, len, dn);
    check(len == 1 + W, "R4 write-only busy length", len, 1 + W);
    check(dn == 1, "R9 done after write", dn, 1);
    peek(40, v); check(v == 8'h12, "R4 byte value", v, 8'h12);

    // R3 equal
    doReq(0, 40, 8'h12, len, dn);
    check(len == 1, "R3 equal busy length", len, 1);
    peek(40, v); check(v == 8'h12, "R3 byte unchanged", v, 8'h12);

    // R5 erase then write, with mid-sequence look
    @(negedge clk);
    reqValid = 1; reqLock = 0; reqAddr = 40; reqData = 8'h35; rdAddr = 40;
    @(negedge clk); reqValid = 0;
    len = 1;
    for (int i = 0; i < E + 1; i++) begin @(negedge clk); if (busy) len++; end
    #1 check(rdData == 8'hFF, "R5 erased during write phase", rdData, 8'hFF);
    while (busy) begin @(negedge clk); if (busy) len++; end
    check(len == 1 + E + W, "R5 erase+write busy length", len, 1 + E + W);
    peek(40, v); check(v == 8'h35, "R5 byte value", v, 8'h35);

    // R7 lock rules
    doReq(0, 5, 8'hA5, len, dn);
    doReq(1, 5, 8'hA4, len, dn);
    check(len == 1, "R7 mismatch no-op", len, 1);
    peekLock(0, v); check(v == 8'hFF, "R7 mismatch keeps bit", v, 8'hFF);
    doReq(1, 5, 8'hA5, len, dn);
    check(len == 1 + W, "R7 lock busy length", len, 1 + W);
    peekLock(0, v); check(v == 8'hDF, "R7 R2 lock bit 5 cleared", v, 8'hDF);
    doReq(1, 40, 8'h35, len, dn);
    check(len == 1, "R7 high address ignored", len, 1);
    for (int k = 1; k < 4; k++) begin
      peekLock(k, v); check(v == 8'hFF, "R7 other lock bytes", v, 8'hFF);
    end
    doReq(1, 5, 8'hA5, len, dn);
    check(len == 1, "R7 already locked no-op", len, 1);
    doReq(1, 31, 8'hFF, len, dn);
    peekLock(3, v); check(v == 8'h7F, "R2 lock bit 31 in byte 3 bit 7", v, 8'h7F);

    // R6 locked byte
    doReq(0, 5, 8'h00, len, dn);
    check(len == 1, "R6 locked busy length", len, 1);
    peek(5, v); check(v == 8'hA5, "R6 locked byte unchanged", v, 8'hA5);
    doReq(0, 6, 8'h0F, len, dn);
    peek(6, v); check(v == 8'h0F, "R6 unlocked neighbour written", v, 8'h0F);

    // R9 request during busy dropped
    @(negedge clk);
    reqValid = 1; reqLock = 0; reqAddr = 50; reqData = 8'h77; rdAddr = 50;
    @(negedge clk); reqValid = 0;
    @(negedge clk);
    reqValid = 1; reqAddr = 51; reqData = 8'h00;
    @(negedge clk); reqValid = 0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    peek(51, v); check(v == 8'hFF, "R9 request while busy dropped", v, 8'hFF);
    peek(50, v); check(v == 8'h77, "R9 first request done", v, 8'h77);

    // R10 abort at erase commit edge
    doReq(0, 60, 8'h10, len, dn);
    @(negedge clk);
    reqValid = 1; reqLock = 0; reqAddr = 60; reqData = 8'h01; rdAddr = 60;
    @(negedge clk); reqValid = 0;
    repeat (E) @(negedge clk);
    abortIn = 1;
    @(negedge clk); abortIn = 0;
    #1;
    check(busy == 0, "R10 abort busy", busy, 0);
    check(done == 0, "R10 abort no done", done, 0);
    check(rdData == 8'h10, "R10 abort before erase commit", rdData, 8'h10);

    // R10 abort mid write phase
    @(negedge clk);
    reqValid = 1; reqAddr = 60; reqData = 8'h01;
    @(negedge clk); reqValid = 0;
    repeat (E + 2) @(negedge clk);
    abortIn = 1;
    @(negedge clk); abortIn = 0;
    #1;
    check(busy == 0, "R10 abort in write busy", busy, 0);
    check(rdData == 8'hFF, "R10 abort after erase", rdData, 8'hFF);
    doReq(0, 60, 8'h01, len, dn);
    check(len == 1 + W, "R10 R4 resume from erased", len, 1 + W);
    peek(60, v); check(v == 8'h01, "R10 final value", v, 8'h01);

    // R10 abort blocks idle request
    @(negedge clk);
    reqValid = 1; abortIn = 1; reqAddr = 70; reqData = 8'h00; rdAddr = 70;
    @(negedge clk); reqValid = 0; abortIn = 0;
    #1 check(busy == 0, "R10 idle abort blocks request", busy, 0);
    repeat (E + W + 3) @(negedge clk);
    peek(70, v); check(v == 8'hFF, "R10 blocked request no change", v, 8'hFF);

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule